// File: doc/BRIEF.md
# Packed Multiply-Accumulate with Wide Accumulator

This block multiplies two 64-bit operands lane by lane, treating each as four 16-bit values, and adds every 32-bit product into a private 48-bit running sum. The four sums form one 192-bit accumulator, kept apart from the ordinary 64-bit data registers. The extra 16 bits of headroom per lane let long dot-product or filter loops run for many iterations before any bit is lost. A per-input mode bit selects whether the lanes are treated as signed or unsigned. A clear command empties the accumulator, or restarts it from the products that arrive with it.

The accumulate path is a two-stage pipeline: the multiply stage is followed by the add stage. It accepts one operand pair per cycle with no stall. A separate read request returns two results one cycle later. The first is a snapshot of the whole 192-bit accumulator. The second is a packed 64-bit word in which each lane's sum has been shifted right by a programmable amount and clamped to 16 bits.

Top module: `pmac_wide`

## Requirements
- R1: After reset every accumulator slice is zero and `rd_valid` is low.
- R2: When `in_valid` is high, the 16-bit lane k of `in_a` (bits 16k+15 down to 16k) is multiplied by lane k of `in_b`. The product is added into the 48-bit slice k of the accumulator (bits 48k+47 down to 48k, lane 0 lowest).
- R3: With `in_signed` high, the lane operands are two's complement and the product is sign-extended to 48 bits. With it low, they are unsigned and the product is zero-extended.
- R4: `in_clear` without `in_valid` sets all slices to zero. `in_clear` with `in_valid` loads the new products in place of the old sums.
- R5: An operation issued in cycle t is visible to a read issued in cycle t+2 or later. A read issued in cycle t or t+1 returns the accumulator as it was before that operation.
- R6: Cycles with neither `in_valid` nor `in_clear` leave the accumulator unchanged.
- R7: `rd_req` in cycle t gives `rd_valid` high in cycle t+1, with `rd_wide` holding the whole accumulator. Without `rd_req`, `rd_valid` is low in the next cycle.
- R8: The packed result lane k (bits 16k+15 down to 16k of `rd_packed`) is slice k shifted right by `rd_shift`. Shift values above 32 count as 32. The shift is arithmetic and the result is clamped to the range -32768..32767 when `rd_signed` is high. The shift is logical and the result is clamped to 0..65535 when `rd_signed` is low.
- R9: Each slice adds modulo 2^48, and carries never cross into a neighbouring slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_clear | input | 1 | Empty the accumulator (or restart it with this cycle's products) |
| in_signed | input | 1 | Lane operands are signed |
| in_a | input | 64 | First packed operand, four 16-bit lanes |
| in_b | input | 64 | Second packed operand, four 16-bit lanes |
| rd_req | input | 1 | Read request |
| rd_signed | input | 1 | Signed shift and clamp for the packed result |
| rd_shift | input | 6 | Right shift for the packed result, capped at 32 |
| rd_valid | output | 1 | Read results valid |
| rd_wide | output | 192 | Snapshot of the full accumulator |
| rd_packed | output | 64 | Shifted and clamped 16-bit lane results |

## Verification
An operation lands in the accumulator two clock edges after it is presented: one edge for the product register and one for the add. Read results appear one edge after the request and are taken from the accumulator value that precedes that edge. The bench therefore keeps two delayed copies of its reference accumulator. Each read is compared against the copy that is two operations old, so reads in the same cycle as an operation or one cycle after it are checked as precisely as reads taken after the pipeline has drained. Inputs change on the falling edge, and outputs are sampled on the next falling edge, after the single register of the read path.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
  localparam int PM_LANES     = 4;
  localparam int PM_LANE_W    = 16;
  localparam int PM_ACC_W     = 48;
  localparam int PM_SHIFT_W   = 6;
  localparam int PM_MAX_SHIFT = 32;
endpackage

// File: rtl/pmac_lane_mul.sv
module pmac_lane_mul #(
  parameter int LANE_W = 16,
  parameter int ACC_W  = 48
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              sgn_i,
  output logic [ACC_W-1:0]  prod_o
);
  localparam int P_W = 2 * LANE_W + 2;

  logic signed [LANE_W:0] ext_a;
  logic signed [LANE_W:0] ext_b;
  logic signed [P_W-1:0]  prod;

  // One extra bit per operand covers both modes: it is the sign bit in
  // signed mode and zero in unsigned mode.
  always_comb begin
    ext_a  = {sgn_i & a_i[LANE_W-1], a_i};
    ext_b  = {sgn_i & b_i[LANE_W-1], b_i};
    prod   = ext_a * ext_b;
    prod_o = {{(ACC_W-P_W){prod[P_W-1]}}, prod};
  end
endmodule

// File: rtl/pmac_acc_slice.sv
module pmac_acc_slice #(
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid_i,
  input  logic             op_clear_i,
  input  logic [ACC_W-1:0] prod_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  always_comb begin
    acc_en = op_valid_i | op_clear_i;
    if (op_clear_i) begin
      acc_d = op_valid_i ? prod_i : '0;
    end else begin
      acc_d = acc_q + prod_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/pmac_pack_sat.sv
module pmac_pack_sat #(
  parameter int ACC_W     = 48,
  parameter int OUT_W     = 16,
  parameter int SHIFT_W   = 6,
  parameter int MAX_SHIFT = 32
) (
  input  logic [ACC_W-1:0]   slice_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               sgn_i,
  output logic [OUT_W-1:0]   sat_o
);
  localparam logic [SHIFT_W-1:0] SH_CAP = SHIFT_W'(MAX_SHIFT);

  logic [SHIFT_W-1:0] amt;
  logic [ACC_W-1:0]   shifted;
  logic               s_fits;
  logic               u_fits;

  always_comb begin
    amt = (shift_i > SH_CAP) ? SH_CAP : shift_i;
    if (sgn_i) begin
      shifted = $signed(slice_i) >>> amt;
    end else begin
      shifted = slice_i >> amt;
    end
    // Signed fit: every bit from the top down to the output sign bit agrees.
    s_fits = (shifted[ACC_W-1:OUT_W-1] == '0) || (shifted[ACC_W-1:OUT_W-1] == '1);
    u_fits = (shifted[ACC_W-1:OUT_W] == '0);
    if (sgn_i) begin
      if (s_fits) begin
        sat_o = shifted[OUT_W-1:0];
      end else if (shifted[ACC_W-1]) begin
        sat_o = {1'b1, {(OUT_W-1){1'b0}}};
      end else begin
        sat_o = {1'b0, {(OUT_W-1){1'b1}}};
      end
    end else begin
      sat_o = u_fits ? shifted[OUT_W-1:0] : '1;
    end
  end
endmodule

// File: rtl/pmac_wide.sv
module pmac_wide
  import pmac_pkg::*;
#(
  parameter int LANES     = PM_LANES,
  parameter int LANE_W    = PM_LANE_W,
  parameter int ACC_W     = PM_ACC_W,
  parameter int SHIFT_W   = PM_SHIFT_W,
  parameter int MAX_SHIFT = PM_MAX_SHIFT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_clear,
  input  logic                      in_signed,
  input  logic [LANES*LANE_W-1:0]   in_a,
  input  logic [LANES*LANE_W-1:0]   in_b,
  input  logic                      rd_req,
  input  logic                      rd_signed,
  input  logic [SHIFT_W-1:0]        rd_shift,
  output logic                      rd_valid,
  output logic [LANES*ACC_W-1:0]    rd_wide,
  output logic [LANES*LANE_W-1:0]   rd_packed
);
  localparam int OP_W   = LANES * LANE_W;
  localparam int WIDE_W = LANES * ACC_W;

  logic [WIDE_W-1:0] mul_p;
  logic [WIDE_W-1:0] s1_prod_q;
  logic              s1_valid_q;
  logic              s1_clear_q;
  logic [WIDE_W-1:0] acc_q_all;
  logic [OP_W-1:0]   pack_d;

  logic              rd_valid_q;
  logic [WIDE_W-1:0] rd_wide_q;
  logic [OP_W-1:0]   rd_packed_q;

  // Multiply stage and accumulate stage, one set per lane.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pmac_lane_mul #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_mul (
      .a_i    (in_a[k*LANE_W +: LANE_W]),
      .b_i    (in_b[k*LANE_W +: LANE_W]),
      .sgn_i  (in_signed),
      .prod_o (mul_p[k*ACC_W +: ACC_W])
    );

    pmac_acc_slice #(.ACC_W(ACC_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid_i (s1_valid_q),
      .op_clear_i (s1_clear_q),
      .prod_i     (s1_prod_q[k*ACC_W +: ACC_W]),
      .acc_o      (acc_q_all[k*ACC_W +: ACC_W])
    );

    pmac_pack_sat #(
      .ACC_W(ACC_W), .OUT_W(LANE_W), .SHIFT_W(SHIFT_W), .MAX_SHIFT(MAX_SHIFT)
    ) u_sat (
      .slice_i (acc_q_all[k*ACC_W +: ACC_W]),
      .shift_i (rd_shift),
      .sgn_i   (rd_signed),
      .sat_o   (pack_d[k*LANE_W +: LANE_W])
    );
  end

  // Product register between the multiply and add stages.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_clear_q <= 1'b0;
    end else begin
      s1_valid_q <= in_valid;
      s1_clear_q <= in_clear;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_prod_q <= '0;
    end else if (in_valid) begin
      s1_prod_q <= mul_p;
    end
  end

  // Read port: snapshot taken from the accumulator value before this edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_wide_q   <= '0;
      rd_packed_q <= '0;
    end else if (rd_req) begin
      rd_wide_q   <= acc_q_all;
      rd_packed_q <= pack_d;
    end
  end

  assign rd_valid  = rd_valid_q;
  assign rd_wide   = rd_wide_q;
  assign rd_packed = rd_packed_q;
endmodule

// File: rtl/pmac_wide_chk.sv
module pmac_wide_chk #(
  parameter int WIDE_W = 192
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_clear,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [WIDE_W-1:0] rd_wide,
  input logic [WIDE_W-1:0] acc
);
  assert_rd_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  assert_rd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R5: the snapshot is the accumulator as sampled at the request edge.
  assert_rd_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rd_wide == $past(acc)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(in_valid, 2) && !$past(in_clear, 2)) |-> (acc == $past(acc)));

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_clear, 2) && !$past(in_valid, 2)) |-> (acc == '0));
endmodule

bind pmac_wide pmac_wide_chk #(.WIDE_W(LANES*ACC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_clear (in_clear),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .rd_wide  (rd_wide),
  .acc      (acc_q_all)
);

// File: tb/pmac_wide_tb_top.sv
module pmac_wide_tb_top;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_clear;
  logic         in_signed;
  logic [63:0]  in_a;
  logic [63:0]  in_b;
  logic         rd_req;
  logic         rd_signed;
  logic [5:0]   rd_shift;
  logic         rd_valid;
  logic [191:0] rd_wide;
  logic [63:0]  rd_packed;

  int tests;
  int fails;
  bit finished;

  // Reference accumulator after all issued ops (h1) and as a read sees it (h2).
  logic [191:0] h1;
  logic [191:0] h2;

  pmac_wide dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_clear(in_clear),
    .in_signed(in_signed), .in_a(in_a), .in_b(in_b), .rd_req(rd_req),
    .rd_signed(rd_signed), .rd_shift(rd_shift), .rd_valid(rd_valid),
    .rd_wide(rd_wide), .rd_packed(rd_packed)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [47:0] lane_prod(logic [15:0] a, logic [15:0] b, bit s);
    longint pa;
    longint pb;
    longint p;
    pa = s ? longint'($signed(a)) : longint'(a);
    pb = s ? longint'($signed(b)) : longint'(b);
    p  = pa * pb;
    return p[47:0];
  endfunction

  function automatic logic [191:0] apply_op(logic [191:0] m, bit v, bit c, bit s,
                                            logic [63:0] a, logic [63:0] b);
    logic [191:0] r;
    r = m;
    for (int k = 0; k < 4; k++) begin
      logic [47:0] p;
      p = lane_prod(a[k*16 +: 16], b[k*16 +: 16], s);
      if (c) r[k*48 +: 48] = v ? p : 48'd0;
      else if (v) r[k*48 +: 48] = m[k*48 +: 48] + p;
    end
    return r;
  endfunction

  function automatic logic [63:0] pack_ref(logic [191:0] m, bit s, int sh);
    logic [63:0] r;
    int amt;
    amt = (sh > 32) ? 32 : sh;
    for (int k = 0; k < 4; k++) begin
      logic [47:0] sl;
      longint v;
      sl = m[k*48 +: 48];
      if (s) begin
        v = {{16{sl[47]}}, sl};
        v = v >>> amt;
        if (v > 32767) v = 32767;
        else if (v < -32768) v = -32768;
      end else begin
        v = {16'd0, sl};
        v = v >> amt;
        if (v > 65535) v = 65535;
      end
      r[k*16 +: 16] = v[15:0];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [191:0] act, logic [191:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check read results at the next one.
  task automatic step(bit v, bit c, bit s, logic [63:0] a, logic [63:0] b,
                      bit rq, bit rs, int sh, string tag);
    logic [191:0] vis;
    vis = h2;
    in_valid = v; in_clear = c; in_signed = s; in_a = a; in_b = b;
    rd_req = rq; rd_signed = rs; rd_shift = 6'(sh);
    h2 = h1;
    h1 = apply_op(h1, v, c, s, a, b);
    @(negedge clk);
    in_valid = 1'b0; in_clear = 1'b0; rd_req = 1'b0;
    if (rq) begin
      check({tag, " R7 valid"}, {191'd0, rd_valid}, 192'd1);
      check({tag, " wide"}, rd_wide, vis);
      check({tag, " R8 packed"}, {128'd0, rd_packed}, {128'd0, pack_ref(vis, rs, sh)});
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 64'd0, 64'd0, 0, 0, 0, "idle");
  endtask

  task automatic rd(bit rs, int sh, string tag);
    step(0, 0, 0, 64'd0, 64'd0, 1, rs, sh, tag);
  endtask

  function automatic logic [15:0] pick16();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tests = 0; fails = 0; finished = 0;
    h1 = '0; h2 = '0;
    rst_n = 1'b0; in_valid = 0; in_clear = 0; in_signed = 0;
    in_a = '0; in_b = '0; rd_req = 0; rd_signed = 0; rd_shift = '0;
    repeat (3) @(negedge clk);
    check("R1 valid low in reset", {191'd0, rd_valid}, 192'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, 0, "R1 zero after reset");
    idle(1);
    check("R7 valid low without request", {191'd0, rd_valid}, 192'd0);

    // R2 unsigned lanes land in their own slices.
    step(1, 0, 0, 64'hFFFF_8000_0003_0001, 64'hFFFF_0002_0005_1234, 0, 0, 0, "R2");
    idle(1);
    rd(0, 0, "R2 unsigned lanes");
    // R5: read in the same cycle as an op, and one cycle after it.
    step(1, 0, 0, 64'h0001_0001_0001_0001, 64'h0010_0020_0030_0040, 1, 0, 0, "R5 same cycle");
    rd(0, 4, "R5 next cycle");
    rd(0, 4, "R5 two later");
    // R6: idle cycles hold.
    idle(5);
    rd(0, 0, "R6 hold");
    // R4: clear alone, then clear with load.
    step(0, 1, 0, 64'd0, 64'd0, 0, 0, 0, "R4");
    idle(1);
    rd(0, 0, "R4 clear alone");
    step(1, 0, 0, 64'h0002_0002_0002_0002, 64'h0003_0003_0003_0003, 0, 0, 0, "R4");
    step(1, 1, 0, 64'h0005_0006_0007_0008, 64'h0001_0001_0001_0001, 0, 0, 0, "R4");
    idle(1);
    rd(0, 0, "R4 clear with load");
    // R3 signed: -1 * 1 gives all-ones slices.
    step(1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 0, 0, 0, "R3");
    idle(1);
    rd(1, 0, "R3 signed extend");
    rd(0, 0, "R3 unsigned clamp of negative");
    // R9: adding 1 to all-ones wraps to zero in every slice.
    step(1, 0, 0, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001, 0, 0, 0, "R9");
    idle(1);
    rd(0, 0, "R9 wrap");
    // R8: large signed products with shifts and the shift cap.
    step(1, 1, 1, 64'h7FFF_8000_7FFF_8000, 64'h7FFF_7FFF_0001_FFFF, 0, 0, 0, "R8");
    idle(1);
    rd(1, 0, "R8 signed clamp");
    rd(1, 16, "R8 shift 16");
    rd(1, 40, "R8 shift capped");
    rd(0, 20, "R8 unsigned shift");

    // Random mix.
    for (int i = 0; i < 600; i++) begin
      bit v, c, s, rq, rs;
      logic [63:0] a, b;
      v  = ($urandom % 4) != 0;
      c  = ($urandom % 16) == 0;
      s  = $urandom % 2;
      rq = ($urandom % 3) == 0;
      rs = $urandom % 2;
      a  = {pick16(), pick16(), pick16(), pick16()};
      b  = {pick16(), pick16(), pick16(), pick16()};
      step(v, c, s, a, b, rq, rs, int'($urandom_range(0, 40)), "R2 R3 R5 random");
    end
    idle(2);
    rd(1, 8, "R6 final");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule